// File: doc/BRIEF.md
# Wideband AGC Loop Controller

This block closes the gain loop of a wideband front end. Each clock it takes one signed gain-error value, where a positive value means the front end has too much gain. It drives a single-bit sigma-delta stream. An external variable-gain stage is steered by the duty factor of that stream, after an external low-pass filter has removed the high-frequency content of the bit stream.

An 8-bit control word selects how the loop is built. In external-integration mode the scaled error goes straight to the modulator, and an analog integrating filter outside the chip closes a first-order loop. In internal-integration mode a saturating digital accumulator integrates the error. Before each addition the error is shifted right by a programmable amount, which sets the loop time constant. The modulator is then driven by the accumulator value.

Three further controls are available. An active-low hold freezes the internal accumulator. A polarity bit complements the output stream. A three-bit field selects the time constant.

Top module: `wbagc_loop`

## Requirements
- R1: While `rst` is high, `sd_o` is 0 and the internal state returns to its reset values: accumulator 0, modulator at mid-scale, control word `CTRL_RST`.
- R2: A value presented on `ctrl_i` is captured on a rising edge and governs the output bit produced on the following edge.
- R3: When control bit 0 is 1 (external integration), the long-run fraction of ones on `sd_o` equals (`err_i` + 2^(ERR_W-1)) / 2^ERR_W, to within one bit over any window.
- R4: When control bit 0 is 0, the modulator input is the internal accumulator. While tracking, the accumulator adds `err_i` arithmetically shifted right by SHIFT_BASE + ctrl[7:5] on each clock.
- R5: A larger value of ctrl[7:5] gives a smaller step per clock. Field value 0 is the fastest setting and 7 the slowest, and with the defaults a value of 7 turns an error of 256 into a zero step.
- R6: The accumulator saturates at +2^(INT_W-1)-1 and -2^(INT_W-1) and never wraps.
- R7: When ctrl[2] is 0 in internal mode, the accumulator keeps its value whatever the value of `err_i`.
- R8: In external mode the accumulator is left untouched. Switching between modes never clears it.
- R9: When ctrl[1] is 1, `sd_o` is the complement of the stream produced with ctrl[1] at 0. This holds in both modes.
- R10: After reset, a zero error in internal mode gives a 50% duty factor on `sd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one error sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_i | input | 8 | Control word: [0] external-integration mode, [1] invert, [2] track (0 = hold), [4:3] no effect, [7:5] time constant |
| err_i | input | ERR_W | Signed gain error; positive means too much gain |
| sd_o | output | 1 | Sigma-delta output bit |

## Verification
The assertions assume that `err_i` and `ctrl_i` are stable around each rising edge and that `err_i` is a two's complement value of ERR_W bits. The no-wrap checks rely on the sign of the shifted error matching the sign of `err_i`. The bench changes every input only on the falling clock edge. It keeps the error inside its signed range, including both extremes, and a behavioural model predicts every output bit.

// File: rtl/wbagc_pkg.sv
`timescale 1ns/1ps
package wbagc_pkg;

    // Control word layout; spare bits are carried but have no effect.
    typedef struct packed {
        logic [2:0] tconst;
        logic [1:0] spare;
        logic       track;
        logic       invert;
        logic       ext_mode;
    } agc_ctrl_t;

endpackage

// File: rtl/wbagc_integ.sv
`timescale 1ns/1ps
module wbagc_integ #(
    parameter int ERR_W      = 12,
    parameter int INT_W      = 16,
    parameter int SHIFT_BASE = 2,
    parameter int TC_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic [TC_W-1:0]         tconst_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [INT_W-1:0] integ_o
);
    localparam int SUM_W = INT_W + 1;
    localparam int SH_W  = $clog2(SHIFT_BASE + (1 << TC_W)) + 1;
    localparam logic signed [SUM_W-1:0] MAX_V = $signed({2'b00, {(INT_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] MIN_V = $signed({2'b11, {(INT_W-1){1'b0}}});

    typedef struct packed {
        logic signed [INT_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;

    logic signed [SUM_W-1:0] err_ext;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum;
    logic [SH_W-1:0]         shamt;

    always_comb begin
        st_d    = st_q;
        err_ext = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};
        shamt   = SH_W'(SHIFT_BASE) + SH_W'(tconst_i);
        step    = err_ext >>> shamt;
        sum     = {st_q.acc[INT_W-1], st_q.acc} + step;
        if (en_i) begin
            if (sum > MAX_V)      st_d.acc = MAX_V[INT_W-1:0];
            else if (sum < MIN_V) st_d.acc = MIN_V[INT_W-1:0];
            else                  st_d.acc = sum[INT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign integ_o = st_q.acc;
endmodule

// File: rtl/wbagc_sdm.sv
`timescale 1ns/1ps
module wbagc_sdm #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x_i,
    input  logic                inv_i,
    output logic                bit_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         out;
    } sdm_st_t;

    sdm_st_t    st_d, st_q;
    logic [W-1:0] ux;
    logic [W:0]   sum;

    always_comb begin
        ux       = {~x_i[W-1], x_i[W-2:0]};
        sum      = {1'b0, st_q.acc} + {1'b0, ux};
        st_d.acc = sum[W-1:0];
        st_d.out = sum[W] ^ inv_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc <= {1'b1, {(W-1){1'b0}}};
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.out;
endmodule

// File: rtl/wbagc_loop.sv
`timescale 1ns/1ps
module wbagc_loop
    import wbagc_pkg::*;
#(
    parameter int         ERR_W      = 12,
    parameter int         INT_W      = 16,
    parameter int         SHIFT_BASE = 2,
    parameter logic [7:0] CTRL_RST   = 8'h04
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              ctrl_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic                    sd_o
);
    localparam int PAD_W = INT_W - ERR_W;

    agc_ctrl_t               ctrl_d, ctrl_q;
    logic signed [INT_W-1:0] integ_w;
    logic signed [INT_W-1:0] err_fs;
    logic signed [INT_W-1:0] mod_x;

    always_comb begin
        ctrl_d = agc_ctrl_t'(ctrl_i);
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= agc_ctrl_t'(CTRL_RST);
        else     ctrl_q <= ctrl_d;
    end

    // Scale the raw error to modulator full scale
    generate
        if (PAD_W > 0) begin : g_pad
            assign err_fs = {err_i, {PAD_W{1'b0}}};
        end else begin : g_same
            assign err_fs = err_i;
        end
    endgenerate

    assign mod_x = ctrl_q.ext_mode ? err_fs : integ_w;

    wbagc_integ #(
        .ERR_W(ERR_W), .INT_W(INT_W), .SHIFT_BASE(SHIFT_BASE), .TC_W(3)
    ) integ_i (
        .clk(clk), .rst(rst),
        .en_i(!ctrl_q.ext_mode && ctrl_q.track),
        .tconst_i(ctrl_q.tconst),
        .err_i(err_i),
        .integ_o(integ_w)
    );

    wbagc_sdm #(.W(INT_W)) sdm_i (
        .clk(clk), .rst(rst),
        .x_i(mod_x), .inv_i(ctrl_q.invert),
        .bit_o(sd_o)
    );
endmodule

// File: rtl/wbagc_loop_chk.sv
`timescale 1ns/1ps
module wbagc_loop_chk #(
    parameter int ERR_W = 12,
    parameter int INT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [7:0]              ctrl_i,
    input logic [7:0]              ctrl_q,
    input logic signed [ERR_W-1:0] err_i,
    input logic signed [INT_W-1:0] integ
);
    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ctrl_q == $past(ctrl_i)); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && !ctrl_q[2]) |=> $stable(integ)); // R7

    AST_EXT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[0] |=> $stable(integ)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && ctrl_q[2] && !err_i[ERR_W-1] && !integ[INT_W-1]) |=> !integ[INT_W-1]); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && ctrl_q[2] && err_i[ERR_W-1] && integ[INT_W-1]) |=> integ[INT_W-1]); // R6
endmodule

bind wbagc_loop wbagc_loop_chk #(.ERR_W(ERR_W), .INT_W(INT_W)) chk_i (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .ctrl_q(ctrl_q),
    .err_i(err_i), .integ(integ_w)
);

// File: tb/wbagc_loop_tb.sv
`timescale 1ns/1ps
module wbagc_loop_tb_top;
    localparam int ERR_W = 12;
    localparam int INT_W = 16;
    localparam int BASE  = 2;
    localparam int FS    = 1 << INT_W;
    localparam int HALF  = 1 << (INT_W-1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [7:0]              ctrl_i = 8'h04;
    logic signed [ERR_W-1:0] err_i = '0;
    logic                    sd_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "R1";
    bit    done = 1'b0;

    // Behavioural reference state
    int m_ctrl = 8'h04;
    int m_integ = 0;
    int m_acc = HALF;
    int m_out = 0;

    always #2.5 clk = ~clk;

    wbagc_loop #(.ERR_W(ERR_W), .INT_W(INT_W), .SHIFT_BASE(BASE)) dut_i (
        .clk(clk), .rst(rst), .ctrl_i(ctrl_i), .err_i(err_i), .sd_o(sd_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int e, x, s, nxt;
        if (rst) begin
            m_ctrl = 8'h04; m_integ = 0; m_acc = HALF; m_out = 0;
        end else begin
            e = int'(err_i);
            x = m_ctrl[0] ? e * (1 << (INT_W-ERR_W)) : m_integ;
            s = m_acc + x + HALF;
            m_out = ((s >= FS) ? 1 : 0) ^ m_ctrl[1];
            m_acc = s % FS;
            if (!m_ctrl[0] && m_ctrl[2]) begin
                nxt = m_integ + (e >>> (BASE + ((m_ctrl >> 5) & 7)));
                if (nxt > HALF - 1) nxt = HALF - 1;
                if (nxt < -HALF)    nxt = -HALF;
                m_integ = nxt;
            end
            m_ctrl = int'(ctrl_i);
        end
    end

    // Cycle-by-cycle comparison against the model (R2 timing included)
    always @(negedge clk) begin
        if (!done) check(sd_o == m_out[0], phase, int'(sd_o), m_out);
    end

    task automatic count_ones(input int n, output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            ones += int'(sd_o);
        end
    endtask

    task automatic apply(input logic [7:0] c, input int e, input int settle);
        @(negedge clk);
        ctrl_i = c;
        err_i  = ERR_W'(e);
        repeat (settle) @(negedge clk);
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int ones;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(sd_o == 1'b0, "R1", int'(sd_o), 0);
        rst = 1'b0;

        // R10: mid-scale start, zero error, internal mode
        phase = "R10";
        count_ones(64, ones);
        check(ones >= 31 && ones <= 33, "R10", ones, 32);

        // R5: slowest time constant makes a small error vanish
        phase = "R5";
        apply(8'hE4, 256, 100);
        count_ones(64, ones);
        check(ones >= 31 && ones <= 33, "R5", ones, 32);

        // R4: fastest time constant integrates upward
        phase = "R4";
        apply(8'h04, 256, 100);
        apply(8'h00, 0, 4);
        count_ones(256, ones);
        check(ones >= 140, "R4", ones, 153);

        // R6: positive saturation
        phase = "R6";
        apply(8'h04, 2047, 200);
        count_ones(1024, ones);
        check(ones >= 1021, "R6", ones, 1023);
        // R6: negative saturation
        apply(8'h04, -2048, 300);
        count_ones(1024, ones);
        check(ones <= 2, "R6", ones, 0);

        // R7: hold keeps the accumulator at its minimum
        phase = "R7";
        apply(8'h00, 2047, 4);
        count_ones(256, ones);
        check(ones <= 2, "R7", ones, 0);

        // R3: external mode duty factor
        phase = "R3";
        apply(8'h05, 1024, 4);
        count_ones(1024, ones);
        check(ones >= 767 && ones <= 769, "R3", ones, 768);
        apply(8'h01, -1536, 4);
        count_ones(1024, ones);
        check(ones >= 127 && ones <= 129, "R3", ones, 128);

        // R9: inversion in external mode
        phase = "R9";
        apply(8'h07, 1024, 4);
        count_ones(1024, ones);
        check(ones >= 255 && ones <= 257, "R9", ones, 256);

        // R8: external mode left the accumulator at its minimum
        phase = "R8";
        apply(8'h00, 2047, 4);
        count_ones(256, ones);
        check(ones <= 2, "R8", ones, 0);

        // R9: inversion in internal mode
        phase = "R9";
        apply(8'h02, 0, 4);
        count_ones(256, ones);
        check(ones >= 254, "R9", ones, 256);

        // R2: rapid control changes, checked against the model every clock
        phase = "R2";
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ctrl_i = 8'((i * 37) ^ 8'h04);
            err_i  = ERR_W'((i * 301) - 2000);
        end
        repeat (8) @(negedge clk);

        finish_up();
    end
endmodule